// File: doc/BRIEF.md
# Vector Memory Address Sequencer

This block turns one vector memory instruction into a stream of element addresses, one per clock. A start pulse captures the addressing mode, a base address, a scalar stride and the runtime vector length. The block then offers addresses on a valid/ready handshake until the requested number of elements has been accepted. It finishes with a one-cycle done pulse. Data movement, bank arbitration and the memory itself belong to the consumer.

Four modes share one counter and one running accumulator. Unit stride steps the address by one element. Constant stride steps it by the captured scalar. Indexed mode, used for both gathers and scatters, adds the base to an index element that the block requests by element number on `elem`. The consumer's register file returns that element combinationally on `idx_in`. Index-generation mode emits 0, m, 2m, … so that the consumer can write a vector of gather offsets. Addresses count elements. The byte address is the element address times eight.

Top module: `vec_addr_gen`

## Requirements
- R1: With mode 2'b00 (unit stride), element i carries address base + i.
- R2: With mode 2'b01 (constant stride), element i carries address base + i × stride, taken modulo 2^AW, so a stride of all-ones steps backwards.
- R3: With mode 2'b10 (indexed), element i carries base + idx_in, with idx_in zero-extended. It is the index element the block asks for by presenting i on `elem`. The form is the same for loads and stores, and the store flag captured at start is echoed on `acc_wr` for every element.
- R4: A run offers exactly min(vlen, MAXVL) addresses, numbered on `elem` as 0, 1, 2, … in order. A vlen of zero offers none.
- R5: With mode 2'b11 (index generation), element i carries i × stride, and base has no effect.
- R6: `byte_addr` always equals the element address shifted left by three bits (8-byte elements).
- R7: While valid is high and ready is low, the address and element number hold steady, and no element is consumed.
- R8: Done is high for exactly one cycle: the cycle after the last address is accepted. For vlen zero it is the cycle after the start is captured. Valid is low whenever done is high.
- R9: A start pulse that arrives while a run is in progress is ignored. Mode, base, stride, vlen and the store flag are sampled only when a run is started.
- R10: During and just after reset, valid and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run; taken only while idle |
| mode | input | 2 | 00 unit, 01 strided, 10 indexed, 11 index generation |
| store | input | 1 | Marks the run as a store (scatter) |
| base | input | AW | Base element address |
| stride | input | AW | Scalar stride, or step m in index generation |
| vlen | input | LW | Requested element count, clamped to MAXVL |
| idx_in | input | IW | Index element selected by `elem` |
| ready | input | 1 | Consumer accepts the offered address |
| valid | output | 1 | An address is offered |
| addr | output | AW | Element address |
| byte_addr | output | AW+3 | Byte address (addr × 8) |
| elem | output | EW | Current element number |
| acc_wr | output | 1 | Store flag of the current run |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The bench sweeps every mode against lengths of 0, 1, 2, 3, 17, 63, 64, 65 and 127, with two strides including a negative one, and with the consumer both always ready and stalling on a pseudo-random pattern. The length boundaries catch an off-by-one terminal count. Such a design would give one address too many or too few, or would run on past MAXVL instead of clamping. A zero length would otherwise wrap into a full-length run. Stalls expose an accumulator or counter that advances without acceptance: the address would change under a held valid, or elements would be skipped. A second start pulse in the middle of a run, carrying different operands, checks that operands are latched only at start. A design that re-sampled them would produce addresses from the wrong base or mode. Done is checked in every cycle, which catches a pulse that comes one cycle early, one cycle late, or more than once.

// File: rtl/vec_addr_gen.sv
module vec_addr_gen #(
  parameter int AW    = 32,
  parameter int IW    = 16,
  parameter int MAXVL = 64,
  localparam int EW   = $clog2(MAXVL),
  localparam int LW   = EW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    mode,
  input  logic          store,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] stride,
  input  logic [LW-1:0] vlen,
  input  logic [IW-1:0] idx_in,
  input  logic          ready,
  output logic          valid,
  output logic [AW-1:0] addr,
  output logic [AW+2:0] byte_addr,
  output logic [EW-1:0] elem,
  output logic          acc_wr,
  output logic          done
);

  localparam logic [1:0] M_UNIT = 2'b00;
  localparam logic [1:0] M_IDX  = 2'b10;
  localparam logic [1:0] M_IOTA = 2'b11;

  logic          run, dn, wr;
  logic [1:0]    md;
  logic [AW-1:0] b, stp, acc;
  logic [EW-1:0] cnt, last_e;
  logic [LW-1:0] len_c;
  logic [AW-1:0] step;

  assign len_c = (vlen > LW'(MAXVL)) ? LW'(MAXVL) : vlen;
  assign step  = (md == M_UNIT) ? AW'(1) : stp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      dn     <= 1'b0;
      wr     <= 1'b0;
      md     <= M_UNIT;
      b      <= '0;
      stp    <= '0;
      acc    <= '0;
      cnt    <= '0;
      last_e <= '0;
    end else begin
      dn <= 1'b0;
      if (!run && start) begin
        md     <= mode;
        wr     <= store;
        b      <= base;
        stp    <= stride;
        acc    <= (mode == M_IOTA) ? '0 : base;
        cnt    <= '0;
        last_e <= EW'(len_c - LW'(1));
        run    <= (len_c != '0);
        dn     <= (len_c == '0);
      end else if (run && ready) begin
        cnt <= cnt + EW'(1);
        acc <= acc + step;
        if (cnt == last_e) begin
          run <= 1'b0;
          dn  <= 1'b1;
        end
      end
    end
  end

  assign valid     = run;
  assign done      = dn;
  assign elem      = cnt;
  assign acc_wr    = wr;
  assign addr      = (md == M_IDX) ? (b + {{(AW-IW){1'b0}}, idx_in}) : acc;
  assign byte_addr = {addr, 3'b000};

endmodule

// File: rtl/vec_addr_gen_chk.sv
module vec_addr_gen_chk #(
  parameter int AW    = 32,
  parameter int IW    = 16,
  parameter int MAXVL = 64,
  localparam int EW   = $clog2(MAXVL),
  localparam int LW   = EW + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [LW-1:0] vlen,
  input logic          ready,
  input logic          valid,
  input logic [AW-1:0] addr,
  input logic [EW-1:0] elem,
  input logic          done
);

  p_reset_quiet_r10: assert property (@(posedge clk) !rst_n |-> !valid && !done);

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ready |=> valid && $stable(addr) && $stable(elem));

  p_first_elem_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start && !valid && !done && (vlen != '0) |=> valid && (elem == '0));

  p_elem_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    valid && ready |=> !valid || (elem == $past(elem) + EW'(1)));

  p_zero_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start && !valid && (vlen == '0) |=> done && !valid);

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !valid);

  p_done_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(valid && ready) || $past(start && !valid));

endmodule

bind vec_addr_gen vec_addr_gen_chk #(.AW(AW), .IW(IW), .MAXVL(MAXVL)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .vlen(vlen), .ready(ready),
  .valid(valid), .addr(addr), .elem(elem), .done(done)
);

// File: tb/tb_vec_addr_gen.sv
`timescale 1ns/1ps
module tb_vec_addr_gen;
  localparam int AW = 32, IW = 16, EW = 6, LW = 7, MAXVL = 64;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, start, store, ready;
  logic [1:0]    mode;
  logic [AW-1:0] base, stride;
  logic [LW-1:0] vlen;
  logic [IW-1:0] idx_in;
  logic          valid, acc_wr, done;
  logic [AW-1:0] addr;
  logic [AW+2:0] byte_addr;
  logic [EW-1:0] elem;

  int n_chk = 0, n_bad = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit stall_en = 0;

  function automatic logic [IW-1:0] idx_of(input logic [EW-1:0] e);
    return IW'(32'(e) * 1237 + 11);
  endfunction

  assign idx_in = idx_of(elem);

  vec_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .store(store),
    .base(base), .stride(stride), .vlen(vlen), .idx_in(idx_in), .ready(ready),
    .valid(valid), .addr(addr), .byte_addr(byte_addr), .elem(elem),
    .acc_wr(acc_wr), .done(done)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] exp_addr(input logic [1:0] m, input logic [AW-1:0] b,
                                             input logic [AW-1:0] s, input int i);
    case (m)
      2'b00:   return b + AW'(i);
      2'b01:   return b + s * AW'(i);
      2'b10:   return b + AW'(idx_of(EW'(i)));
      default: return s * AW'(i);
    endcase
  endfunction

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'b00:   return "R1 unit";
      2'b01:   return "R2 strided";
      2'b10:   return "R3 indexed";
      default: return "R5 index-gen";
    endcase
  endfunction

  task automatic run_vec(input logic [1:0] m, input logic [AW-1:0] b, input logic [AW-1:0] s,
                         input int len, input bit st);
    int n, i, dones;
    bit lastfire, prev_stall, inject;
    logic [AW-1:0] held_a;
    logic [EW-1:0] held_e;
    @(negedge clk);
    mode = m; base = b; stride = s; vlen = LW'(len); store = st; start = 1'b1; ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    n = (len > MAXVL) ? MAXVL : len;
    inject = (n >= 8);
    i = 0; dones = 0; lastfire = (n == 0); prev_stall = 0; held_a = '0; held_e = '0;
    for (int cyc = 0; cyc < 400; cyc++) begin
      chk(done == lastfire, "R8 done timing", 64'(done), 64'(lastfire));
      if (done) dones++;
      lastfire = 0;
      if (inject && cyc == 2) begin
        start = 1'b1; base = ~b; stride = s + 1; mode = ~m; vlen = 7'd3; store = ~st;
      end
      if (inject && cyc == 3) start = 1'b0;
      if (valid) begin
        chk(i < n, "R4 no extra address", 64'(i), 64'(n));
        if (prev_stall) begin
          chk(addr == held_a, "R7 addr held", 64'(addr), 64'(held_a));
          chk(elem == held_e, "R7 elem held", 64'(elem), 64'(held_e));
        end
        chk(elem == EW'(i), "R4 element order", 64'(elem), 64'(i));
        chk(addr == exp_addr(m, b, s, i), (inject && cyc > 2) ? "R9 latched operands" : mode_tag(m),
            64'(addr), 64'(exp_addr(m, b, s, i)));
        chk(byte_addr == {exp_addr(m, b, s, i), 3'b000}, "R6 byte address",
            64'(byte_addr), 64'({exp_addr(m, b, s, i), 3'b000}));
        chk(acc_wr == st, "R3 store flag", 64'(acc_wr), 64'(st));
        ready = stall_en ? (lfsr[1:0] != 2'b00) : 1'b1;
        prev_stall = !ready;
        held_a = addr; held_e = elem;
        if (ready) begin
          i++;
          if (i == n) lastfire = 1;
        end
      end else begin
        ready = lfsr[0];
        prev_stall = 0;
        if (i == n && !start) break;
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      @(negedge clk);
    end
    ready = 1'b0;
    chk(i == n, "R4 address count", 64'(i), 64'(n));
    chk(dones == 1, "R8 single done", 64'(dones), 64'd1);
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int lens[9] = '{0, 1, 2, 3, 17, 63, 64, 65, 127};
    logic [AW-1:0] strides[2] = '{32'd3, 32'hFFFF_FFF8};
    rst_n = 1'b0; start = 1'b0; store = 1'b0; ready = 1'b0;
    mode = 2'b00; base = '0; stride = '0; vlen = '0;
    repeat (3) @(negedge clk);
    chk(!valid, "R10 valid in reset", 64'(valid), 64'd0);
    chk(!done, "R10 done in reset", 64'(done), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!valid, "R10 valid after reset", 64'(valid), 64'd0);
    chk(!done, "R10 done after reset", 64'(done), 64'd0);
    for (int se = 0; se < 2; se++) begin
      stall_en = (se == 1);
      for (int m = 0; m < 4; m++)
        for (int li = 0; li < 9; li++)
          for (int si = 0; si < 2; si++)
            run_vec(2'(m), 32'h0001_0000 + 32'(m * 977 + li), strides[si], lens[li], 1'(li + si));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule